// File: doc/BRIEF.md
# General-Purpose I/O Controller with Edge Capture

This block is a register-mapped general-purpose I/O controller for a parameterised number of pins, a multiple of 32. Software reaches it over a plain single-cycle read/write bus and can choose each pin's direction, raise or lower outputs through separate set and clear registers, and read the synchronised pin levels. It also stores a two-bit alternate-function code per pin, which is brought out for a pad multiplexer elsewhere.

Each pin input passes through a two-flop synchroniser. A rising or a falling transition that software has armed latches a sticky status bit, and status bits are cleared by writing ones. A single interrupt line is the OR of every status bit. Service code clears status before it handles the event, so an edge that lands in the same cycle as the clear must survive it.

Top module: `gpio_ctl`

## Requirements
- R1: Registers are 32-bit words grouped by type and then by 32-pin word. The byte address is type*W*4 + word*4, where W = pins/32 and word = pin/32. Pin p sits at bit p mod 32. The types are 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status and 7 alternate function, which spans 2*W words. Accesses with bus_addr[1:0] not zero, or beyond the last word, are ignored, and reads of them return zero.
- R2: The level register returns the synchronised pin inputs. Writes to it change nothing.
- R3: In the direction register, a 1 makes the pin an output. pin_oe follows the register, and the register reads back.
- R4: Writing the set register drives pin_out high wherever the write data holds a 1. Zero bits leave the pin unchanged. Reading either the set or the clear address returns the output latch.
- R5: Writing the clear register drives pin_out low wherever the write data holds a 1. Zero bits leave the pin unchanged.
- R6: The alternate-function registers hold 2 bits per pin, 16 pins per word. Pin p uses word p/16 at shift 2*(p mod 16), so its field is alt_sel[2p+1:2p]. The registers read back.
- R7: An edge-status bit is set by a rising edge when its rising enable is 1, or by a falling edge when its falling enable is 1. An edge with its enable at 0 sets nothing. A set bit stays set until a 1 is written to it.
- R8: When a new armed edge and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set. An edge that arrives after a clear sets the bit again.
- R9: irq is high exactly while at least one status bit is set, across all words.
- R10: A pin input change made between two clock edges sets status, and raises irq, after the third rising clock edge that follows the change, and not before.
- R11: Reset (rst_n low at a clock edge) clears the direction, output, enable, status and alternate-function registers, so pin_out, pin_oe, alt_sel and irq are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output latch |
| pin_oe | output | NUM_PINS | Output enable (the direction register) |
| alt_sel | output | 2*NUM_PINS | Alternate-function codes, 2 bits per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
The hardest case to reach is the collision between a clear and a fresh edge on the same status bit in the same cycle. Reaching it means counting the synchroniser and previous-value registers from the pin change to the cycle in which the edge term is live. The bench changes a pin at a falling clock edge, lets exactly two rising edges pass, and then holds a write-one-to-clear across the third rising edge, which is the one at which the status bit latches. It also pins down the R10 latency by sampling irq one cycle before and at the cycle of capture.

// File: rtl/gpio_ctl_pkg.sv
// Shared definitions for the GPIO controller.
// Assumes 32-bit data words and the type order that sets the address map.
package gpio_ctl_pkg;
    localparam int DW = 32;

    typedef enum logic [2:0] {
        RT_LEVEL = 3'd0,
        RT_DIR   = 3'd1,
        RT_SET   = 3'd2,
        RT_CLR   = 3'd3,
        RT_RISE  = 3'd4,
        RT_FALL  = 3'd5,
        RT_STAT  = 3'd6,
        RT_ALTF  = 3'd7
    } reg_type_e;
endpackage

// File: rtl/gpio_ctl_sync.sv
// Multi-stage synchroniser for asynchronous pin inputs.
// Assumes each bit is independent; there is no bus coherency across bits.
module gpio_ctl_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    // Shift the inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_ctl_port.sv
// Direction and output latch for one 32-pin word.
// Assumes at most one of the write strobes is high in a cycle.
module gpio_ctl_port
    import gpio_ctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_dir,
    input  logic          wr_set,
    input  logic          wr_clr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] dir_q,
    output logic [DW-1:0] out_q
);
    // Direction register: plain load.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    // Output latch: ones in set raise, ones in clear lower.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (wr_set) out_q <= out_q | wdata;
        else if (wr_clr) out_q <= out_q & ~wdata;
    end

    p_set_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((out_q & $past(wdata)) == $past(wdata)));
    p_clr_lowers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((out_q & $past(wdata)) == '0));
    p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_set && !wr_clr) |=> $stable(out_q));
endmodule

// File: rtl/gpio_ctl_edge.sv
// Edge detection, enables and sticky status for one 32-pin word.
// Assumes lvl is already synchronised; an edge is lvl differing from its last value.
module gpio_ctl_edge
    import gpio_ctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] lvl,
    input  logic          wr_rise,
    input  logic          wr_fall,
    input  logic          wr_stat,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rise_en,
    output logic [DW-1:0] fall_en,
    output logic [DW-1:0] stat
);
    logic [DW-1:0] prev;
    logic [DW-1:0] hits;
    logic [DW-1:0] clr_mask;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    // Edge enables: plain loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en <= '0;
            fall_en <= '0;
        end else begin
            if (wr_rise) rise_en <= wdata;
            if (wr_fall) fall_en <= wdata;
        end
    end

    // Armed edges this cycle, and the bits a write-one-to-clear targets.
    always_comb begin
        hits     = (lvl & ~prev & rise_en) | (~lvl & prev & fall_en);
        clr_mask = wr_stat ? wdata : '0;
    end

    // Sticky status: a new edge outranks a clear of the same bit.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr_mask) | hits;
    end

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((stat & $past(stat)) == $past(stat)));
    p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((stat & $past(hits)) == $past(hits)));
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((stat & $past(wdata & ~hits)) == '0));
    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> (stat == '0 && rise_en == '0 && fall_en == '0));
endmodule

// File: rtl/gpio_ctl.sv
// GPIO controller top: address decode, per-word banks, alternate-function
// storage, read mux and interrupt OR. Assumes NUM_PINS is a multiple of 32
// and a single-cycle bus with a combinational read.
module gpio_ctl
    import gpio_ctl_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = $clog2(NUM_PINS / 32 * 36)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [2*NUM_PINS-1:0] alt_sel,
    output logic                  irq
);
    localparam int NW  = NUM_PINS / DW;
    localparam int NAF = 2 * NW;
    localparam int NWORDS = 7 * NW + NAF;

    logic [NUM_PINS-1:0] lvl_all;
    logic [NUM_PINS-1:0] stat_all;
    logic [DW-1:0] lvl_w  [NW];
    logic [DW-1:0] dir_w  [NW];
    logic [DW-1:0] out_w  [NW];
    logic [DW-1:0] rise_w [NW];
    logic [DW-1:0] fall_w [NW];
    logic [DW-1:0] stat_w [NW];
    logic [DW-1:0] af_w   [NAF];

    int        word_lin;
    int        sel_word;
    logic      in_map;
    reg_type_e type_code;
    logic [NW-1:0]  wr_dir, wr_set, wr_clr, wr_rise, wr_fall, wr_stat;
    logic [NAF-1:0] wr_af;

    gpio_ctl_sync #(.W(NUM_PINS), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_all)
    );

    // Split the byte address into register type and word index.
    always_comb begin
        word_lin = int'(bus_addr[ADDR_W-1:2]);
        in_map   = (bus_addr[1:0] == 2'b00) && (word_lin < NWORDS);
        if (word_lin >= 7 * NW) begin
            type_code = RT_ALTF;
            sel_word  = word_lin - 7 * NW;
        end else begin
            type_code = reg_type_e'(3'(word_lin / NW));
            sel_word  = word_lin % NW;
        end
    end

    // Per-word write strobes.
    always_comb begin
        for (int w = 0; w < NW; w++) begin
            wr_dir[w]  = bus_wr && in_map && type_code == RT_DIR  && sel_word == w;
            wr_set[w]  = bus_wr && in_map && type_code == RT_SET  && sel_word == w;
            wr_clr[w]  = bus_wr && in_map && type_code == RT_CLR  && sel_word == w;
            wr_rise[w] = bus_wr && in_map && type_code == RT_RISE && sel_word == w;
            wr_fall[w] = bus_wr && in_map && type_code == RT_FALL && sel_word == w;
            wr_stat[w] = bus_wr && in_map && type_code == RT_STAT && sel_word == w;
        end
        for (int a = 0; a < NAF; a++)
            wr_af[a] = bus_wr && in_map && type_code == RT_ALTF && sel_word == a;
    end

    for (genvar w = 0; w < NW; w++) begin : g_word
        assign lvl_w[w] = lvl_all[w*DW +: DW];

        gpio_ctl_port u_port (
            .clk(clk), .rst_n(rst_n),
            .wr_dir(wr_dir[w]), .wr_set(wr_set[w]), .wr_clr(wr_clr[w]),
            .wdata(bus_wdata), .dir_q(dir_w[w]), .out_q(out_w[w])
        );

        gpio_ctl_edge u_edge (
            .clk(clk), .rst_n(rst_n), .lvl(lvl_w[w]),
            .wr_rise(wr_rise[w]), .wr_fall(wr_fall[w]), .wr_stat(wr_stat[w]),
            .wdata(bus_wdata), .rise_en(rise_w[w]), .fall_en(fall_w[w]),
            .stat(stat_w[w])
        );

        assign pin_out[w*DW +: DW]  = out_w[w];
        assign pin_oe[w*DW +: DW]   = dir_w[w];
        assign stat_all[w*DW +: DW] = stat_w[w];
    end

    for (genvar a = 0; a < NAF; a++) begin : g_altf
        // Alternate-function word: 16 two-bit fields.
        always_ff @(posedge clk) begin
            if (!rst_n)      af_w[a] <= '0;
            else if (wr_af[a]) af_w[a] <= bus_wdata;
        end
        assign alt_sel[a*DW +: DW] = af_w[a];
    end

    // Read mux over the selected type and word.
    always_comb begin
        bus_rdata = '0;
        if (in_map) begin
            for (int w = 0; w < NAF; w++) begin
                if (sel_word == w) begin
                    if (type_code == RT_ALTF) bus_rdata = af_w[w];
                    else if (w < NW) begin
                        case (type_code)
                            RT_LEVEL:       bus_rdata = lvl_w[w % NW];
                            RT_DIR:         bus_rdata = dir_w[w % NW];
                            RT_SET, RT_CLR: bus_rdata = out_w[w % NW];
                            RT_RISE:        bus_rdata = rise_w[w % NW];
                            RT_FALL:        bus_rdata = fall_w[w % NW];
                            RT_STAT:        bus_rdata = stat_w[w % NW];
                            default:        bus_rdata = '0;
                        endcase
                    end
                end
            end
        end
    end

    assign irq = |stat_all;

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_wr) |=> irq);
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w[0] != '0) |-> irq);
    p_reset_out_r11: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && pin_oe == '0 && alt_sel == '0));
endmodule

// File: tb/sim_gpio_ctl.sv
module sim_gpio_ctl;
    localparam int NP = 64;
    localparam int AW = 7;
    localparam int NV = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pin_in = '0;
    logic [NP-1:0]   pin_out;
    logic [NP-1:0]   pin_oe;
    logic [2*NP-1:0] alt_sel;
    logic            irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    gpio_ctl #(.NUM_PINS(NP), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel), .irq(irq)
    );

    // Vector: {write, byte address, data (write data or expected read), requirement}.
    localparam logic [44:0] VEC [NV] = '{
        {1'b1, 8'd8,  32'hF0F0_F0F0, 4'd3},   // R3 direction word 0
        {1'b0, 8'd8,  32'hF0F0_F0F0, 4'd3},
        {1'b1, 8'd16, 32'h0000_00FF, 4'd4},   // R4 set
        {1'b0, 8'd16, 32'h0000_00FF, 4'd4},
        {1'b1, 8'd24, 32'h0000_000F, 4'd5},   // R5 clear
        {1'b0, 8'd24, 32'h0000_00F0, 4'd5},
        {1'b1, 8'd20, 32'h8000_0001, 4'd4},   // R4 set word 1
        {1'b1, 8'd28, 32'h0000_0000, 4'd5},   // R5 zero bits no effect
        {1'b0, 8'd20, 32'h8000_0001, 4'd5},
        {1'b1, 8'd68, 32'hC000_0003, 4'd6},   // R6 alt-function word 3
        {1'b0, 8'd68, 32'hC000_0003, 4'd6},
        {1'b0, 8'd56, 32'h0000_0000, 4'd6},
        {1'b1, 8'd0,  32'hFFFF_FFFF, 4'd2},   // R2 level is read-only
        {1'b0, 8'd0,  32'h0000_0000, 4'd2},
        {1'b1, 8'd32, 32'h0000_000F, 4'd7},   // R7 rising enable word 0
        {1'b0, 8'd32, 32'h0000_000F, 4'd7},
        {1'b1, 8'd9,  32'hFFFF_FFFF, 4'd1},   // R1 misaligned write ignored
        {1'b0, 8'd8,  32'hF0F0_F0F0, 4'd1},
        {1'b0, 8'd12, 32'h0000_0000, 4'd1},   // R1 word 1 independent
        {1'b0, 8'd0,  32'h0000_0000, 4'd1}
    };

    task automatic check(input logic [127:0] act, input logic [127:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check(pin_out, '0, "R11 pin_out");
        check(pin_oe, '0, "R11 pin_oe");
        check(alt_sel, '0, "R11 alt_sel");
        check(irq, 1'b0, "R11 irq");

        // Table of register writes and read-backs (R1 through R7).
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][44]) bus_write(VEC[v][43:36], VEC[v][35:4]);
            else begin
                bus_read(VEC[v][43:36], rd);
                check(rd, VEC[v][35:4], $sformatf("R%0d table row %0d", VEC[v][3:0], v));
            end
        end

        // R3 R4 R5 R6 at the ports
        check(pin_oe[31:0], 32'hF0F0_F0F0, "R3 pin_oe");
        check(pin_out[31:0], 32'h0000_00F0, "R5 pin_out word 0");
        check(pin_out[63:32], 32'h8000_0001, "R4 pin_out word 1");
        check(alt_sel[127:126], 2'b11, "R6 pin 63 field");
        check(alt_sel[97:96], 2'b11, "R6 pin 48 field");

        // R2 level readback of pin 33
        pin_in[33] = 1'b1;
        wait_cyc(4);
        bus_read(8'd4, rd);
        check(rd, 32'h2, "R2 level pin 33");
        bus_read(8'd52, rd);
        check(rd, 32'h0, "R7 no enable word 1");

        // R10 latency and R7 capture on pin 0
        pin_in[0] = 1'b1;
        wait_cyc(2);
        check(irq, 1'b0, "R10 irq before capture");
        wait_cyc(1);
        check(irq, 1'b1, "R10 irq at capture");
        bus_read(8'd48, rd);
        check(rd, 32'h1, "R7 status set");
        bus_write(8'd48, 32'h1);
        bus_read(8'd48, rd);
        check(rd, 32'h0, "R7 clear");
        check(irq, 1'b0, "R9 irq low");

        // R7 disarmed falling edge sets nothing
        pin_in[0] = 1'b0;
        wait_cyc(4);
        bus_read(8'd48, rd);
        check(rd, 32'h0, "R7 disabled fall");

        // R7 falling edge on pin 40
        bus_write(8'd44, 32'h100);
        pin_in[40] = 1'b1;
        wait_cyc(4);
        bus_read(8'd52, rd);
        check(rd, 32'h0, "R7 rise not armed");
        pin_in[40] = 1'b0;
        wait_cyc(4);
        bus_read(8'd52, rd);
        check(rd, 32'h100, "R7 fall captured");

        // R9 two bits set, clear one at a time
        pin_in[0] = 1'b1;
        wait_cyc(4);
        bus_write(8'd52, 32'h100);
        check(irq, 1'b1, "R9 irq held by word 0");
        bus_read(8'd52, rd);
        check(rd, 32'h0, "R9 word 1 cleared");
        bus_write(8'd48, 32'h1);
        check(irq, 1'b0, "R9 irq low after all clear");

        // R8 clear colliding with a new edge
        pin_in[0] = 1'b0;
        wait_cyc(4);
        pin_in[0] = 1'b1;
        wait_cyc(2);
        bus_write(8'd48, 32'h1);
        bus_read(8'd48, rd);
        check(rd, 32'h1, "R8 edge beats clear");
        bus_write(8'd48, 32'h1);
        bus_read(8'd48, rd);
        check(rd, 32'h0, "R8 later clear");
        pin_in[0] = 1'b0;
        wait_cyc(2);
        pin_in[0] = 1'b1;
        wait_cyc(4);
        bus_read(8'd48, rd);
        check(rd, 32'h1, "R8 relatched");

        // R11 reset clears everything
        rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        @(negedge clk);
        check(pin_out, '0, "R11 pin_out after run");
        check(pin_oe, '0, "R11 pin_oe after run");
        check(alt_sel, '0, "R11 alt_sel after run");
        check(irq, 1'b0, "R11 irq after run");
        bus_read(8'd32, rd);
        check(rd, 32'h0, "R11 rising enable");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule